// File: doc/BRIEF.md
# Scan-Line Address Sequencer

This block walks the scan lines of a rectangle for a rectangle-copy engine. For each line it gives the word address of the quadword that holds the first bit, and the 6-bit offset of that bit within the quadword, for a source and a destination channel. When the engine strobes that a line is finished, the sequencer adds each channel's signed bits-per-line stride to the bit position. It counts the lines down from the loaded height and signals completion.

When the source is a repeating pattern, the source address is fixed at the pattern base and a 4-bit row index cycles through the pattern rows. The pattern settings are packed into the source-stride input. Between lines the sequencer can park on an interrupt request with all its state kept. A resume pulse continues from that state without any reload. A zero height or zero width ends the operation as soon as it starts.

Top module: `scanline_seq`

## Requirements
- R1: After reset, busy_o, paused_o and done_o are 0, and all address, offset and row outputs are 0.
- R2: On start_i, each channel (outside pattern mode) loads the bit position P = addr*16 + bit, where bit is unsigned and may exceed 63. The address output is (P >> 6) * 4, which is the word address of the quadword with its two low bits zero. The offset output is P mod 64. Both appear in the cycle after start_i, with busy_o = 1.
- R3: A line_done_i while busy, on any line but the last, adds the signed two's-complement stride to that channel's P (modulo 2^(AW+4)). The new address and offset appear in the next cycle. Carries and borrows move across quadwords and across the top of the address range.
- R4: The remaining-line count is loaded from height_i. done_o rises in the cycle after the height-th line_done_i, and busy_o falls in that same cycle. The last strobe leaves the addresses unchanged.
- R5: A start_i with height_i = 0 or width_i = 0 sets done_o in the next cycle, and busy_o stays 0.
- R6: With pattern_en_i = 1 at start, the initial row is r0 = src_stride_i[7:4]. The source address becomes src_addr_i - r0 (modulo 2^AW), the source offset becomes 0, and both stay constant for the whole operation.
- R7: In pattern mode row_o starts at r0 and, on each line advance, goes to 0 if it equals src_stride_i[15:12] (pattern height minus one); otherwise it goes up by one, modulo 16. Outside pattern mode row_o is 0.
- R8: A line_done_i with irq_i = 1 on a non-last line still advances the addresses. The block then enters the parked state: paused_o = 1 and busy_o = 0. While parked, line_done_i has no effect on any output.
- R9: A resume_i while parked returns to busy_o = 1 with the retained addresses, offsets, row and line count. Changes to the configuration inputs meanwhile have no effect.
- R10: line_done_i has no effect when busy_o is 0, and resume_i has no effect outside the parked state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load configuration and begin |
| resume_i | input | 1 | Continue from parked state |
| line_done_i | input | 1 | Current line finished |
| irq_i | input | 1 | Interrupt request, sampled with line_done_i |
| pattern_en_i | input | 1 | Source is a repeating pattern |
| src_addr_i | input | AW | Source word address |
| src_bit_i | input | SW | Source starting bit (unsigned) |
| src_stride_i | input | SW | Source signed stride, or pattern fields in pattern mode |
| dst_addr_i | input | AW | Destination word address |
| dst_bit_i | input | SW | Destination starting bit (unsigned) |
| dst_stride_i | input | SW | Destination signed stride |
| height_i | input | CW | Number of lines |
| width_i | input | CW | Line width in bits (only tested for zero) |
| src_addr_o | output | AW | Source quadword (or pattern base) address |
| src_off_o | output | 6 | Source bit offset in quadword |
| dst_addr_o | output | AW | Destination quadword address |
| dst_off_o | output | 6 | Destination bit offset in quadword |
| row_o | output | 4 | Pattern row index |
| busy_o | output | 1 | Lines are being walked |
| paused_o | output | 1 | Parked on interrupt |
| done_o | output | 1 | Operation complete |

## Verification
A wrong carry between offset and address shows up one cycle after the first line advance whose offset sum leaves 0..63. The stride sweep therefore includes small, quadword-sized and extreme strides of both signs, and it checks every line. A miscounted line counter shows as done_o rising one strobe early or late. A bad pattern wrap shows on row_o at the first line past the pattern height. A park that loses state shows as a changed address or row in the cycle after resume.

// File: rtl/scanline_pkg.sv
package scanline_pkg;
  localparam int OFS_W = 6;
  localparam int ROW_W = 4;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD, ST_FIN} seq_state_e;
endpackage

// File: rtl/line_ctrl.sv
module line_ctrl
  import scanline_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          resume,
  input  logic          line_done,
  input  logic          irq,
  input  logic [CW-1:0] height,
  input  logic [CW-1:0] width,
  output logic          load,
  output logic          step,
  output logic          busy,
  output logic          paused,
  output logic          done
);
  seq_state_e    state_q;
  logic [CW-1:0] left_q;
  logic          empty_job;
  logic          last_line;

  assign empty_job = (height == '0) || (width == '0);
  assign load      = start;
  assign last_line = busy && line_done && (left_q == CW'(1));
  assign step      = busy && line_done && !last_line && !start;
  assign busy      = (state_q == ST_RUN);
  assign paused    = (state_q == ST_HOLD);
  assign done      = (state_q == ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
    end else if (start) begin
      left_q  <= height;
      state_q <= empty_job ? ST_FIN : ST_RUN;
    end else begin
      unique case (state_q)
        ST_RUN: if (line_done) begin
          left_q <= left_q - CW'(1);
          if (last_line)  state_q <= ST_FIN;
          else if (irq)   state_q <= ST_HOLD;
        end
        ST_HOLD: if (resume) state_q <= ST_RUN;
        default: ;
      endcase
    end
  end

  assert_one_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, paused, done}));
  assert_zero_job_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start && empty_job |=> done && !busy);
  assert_last_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    last_line && !start |=> done);
  assert_park_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    paused && !resume && !start |=> paused);
  assert_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
    paused && resume && !start |=> busy && $stable(left_q));
endmodule

// File: rtl/addr_walker.sv
module addr_walker
  import scanline_pkg::*;
#(
  parameter int AW      = 32,
  parameter int SW      = 16,
  parameter bit HAS_PAT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             pat_en,
  input  logic [AW-1:0]    base_addr,
  input  logic [SW-1:0]    bit_in,
  input  logic [SW-1:0]    stride,
  input  logic [ROW_W-1:0] row_init,
  output logic [AW-1:0]    addr,
  output logic [OFS_W-1:0] off
);
  localparam int SUM_W = SW + 2;
  localparam int EXT_W = AW - SUM_W;

  logic [AW-1:0]    addr_q;
  logic [OFS_W-1:0] off_q;
  logic [SW-1:0]    stride_q;
  logic             pat_q;

  // Split a word address plus unsigned bit count into quadword address and offset
  function automatic logic [AW+OFS_W-1:0] f_split(input logic [AW-1:0] a,
                                                   input logic [SW-1:0] b);
    logic [AW-1:0] w;
    w = a + AW'(b >> 4);
    return {w[AW-1:2], 2'b00, w[1:0], b[3:0]};
  endfunction

  // Add a signed stride to offset; whole quadwords carry into the address
  function automatic logic [AW+OFS_W-1:0] f_step(input logic [AW-1:0]    a,
                                                  input logic [OFS_W-1:0] o,
                                                  input logic [SW-1:0]    st);
    logic signed [SUM_W-1:0] s;
    logic signed [SUM_W-1:0] q;
    logic [AW-1:0]           delta;
    s     = $signed({{(SUM_W-OFS_W){1'b0}}, o}) + $signed({{2{st[SW-1]}}, st});
    q     = s >>> OFS_W;
    delta = {{EXT_W{q[SUM_W-1]}}, q};
    return {a + (delta << 2), s[OFS_W-1:0]};
  endfunction

  generate
    if (HAS_PAT) begin : g_pat
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pat_q <= 1'b0;
        else if (load) pat_q <= pat_en;
      end
    end else begin : g_plain
      assign pat_q = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      off_q    <= '0;
      stride_q <= '0;
    end else if (load) begin
      stride_q <= stride;
      if (HAS_PAT && pat_en) begin
        addr_q <= base_addr - AW'(row_init);
        off_q  <= '0;
      end else begin
        {addr_q, off_q} <= f_split(base_addr, bit_in);
      end
    end else if (step && !pat_q) begin
      {addr_q, off_q} <= f_step(addr_q, off_q, stride_q);
    end
  end

  assign addr = addr_q;
  assign off  = off_q;

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !step |=> $stable(addr_q) && $stable(off_q));
  assert_pattern_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pat_q && !load |=> $stable(addr_q) && off_q == '0);
  assert_quad_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load && !(HAS_PAT && pat_en) |=> addr_q[1:0] == 2'b00);
endmodule

// File: rtl/pattern_row.sv
module pattern_row
  import scanline_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             pat_en,
  input  logic [ROW_W-1:0] row_init,
  input  logic [ROW_W-1:0] last_row,
  output logic [ROW_W-1:0] row
);
  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] last_q;
  logic             en_q;
  logic             wrap;

  function automatic logic [ROW_W-1:0] f_next(input logic [ROW_W-1:0] r,
                                               input logic [ROW_W-1:0] lim);
    return (r == lim) ? '0 : r + ROW_W'(1);
  endfunction

  assign wrap = step && en_q && (row_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      last_q <= '0;
      en_q   <= 1'b0;
    end else if (load) begin
      en_q   <= pat_en;
      last_q <= last_row;
      row_q  <= pat_en ? row_init : '0;
    end else if (step && en_q) begin
      row_q <= f_next(row_q, last_q);
    end
  end

  assign row = row_q;

  assert_row_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && !load |=> row_q == '0);
  assert_row_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q && !load |=> row_q == '0);
endmodule

// File: rtl/scanline_seq.sv
module scanline_seq
  import scanline_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             resume_i,
  input  logic             line_done_i,
  input  logic             irq_i,
  input  logic             pattern_en_i,
  input  logic [AW-1:0]    src_addr_i,
  input  logic [SW-1:0]    src_bit_i,
  input  logic [SW-1:0]    src_stride_i,
  input  logic [AW-1:0]    dst_addr_i,
  input  logic [SW-1:0]    dst_bit_i,
  input  logic [SW-1:0]    dst_stride_i,
  input  logic [CW-1:0]    height_i,
  input  logic [CW-1:0]    width_i,
  output logic [AW-1:0]    src_addr_o,
  output logic [OFS_W-1:0] src_off_o,
  output logic [AW-1:0]    dst_addr_o,
  output logic [OFS_W-1:0] dst_off_o,
  output logic [ROW_W-1:0] row_o,
  output logic             busy_o,
  output logic             paused_o,
  output logic             done_o
);
  logic             load_ev;
  logic             step_ev;
  logic [ROW_W-1:0] pat_first;
  logic [ROW_W-1:0] pat_last;

  // Pattern fields share the source stride word
  assign pat_first = src_stride_i[7:4];
  assign pat_last  = src_stride_i[15:12];

  line_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start_i), .resume(resume_i),
    .line_done(line_done_i), .irq(irq_i), .height(height_i), .width(width_i),
    .load(load_ev), .step(step_ev), .busy(busy_o), .paused(paused_o), .done(done_o)
  );

  addr_walker #(.AW(AW), .SW(SW), .HAS_PAT(1'b1)) u_src (
    .clk(clk), .rst_n(rst_n), .load(load_ev), .step(step_ev),
    .pat_en(pattern_en_i), .base_addr(src_addr_i), .bit_in(src_bit_i),
    .stride(src_stride_i), .row_init(pat_first),
    .addr(src_addr_o), .off(src_off_o)
  );

  addr_walker #(.AW(AW), .SW(SW), .HAS_PAT(1'b0)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(load_ev), .step(step_ev),
    .pat_en(1'b0), .base_addr(dst_addr_i), .bit_in(dst_bit_i),
    .stride(dst_stride_i), .row_init('0),
    .addr(dst_addr_o), .off(dst_off_o)
  );

  pattern_row u_row (
    .clk(clk), .rst_n(rst_n), .load(load_ev), .step(step_ev),
    .pat_en(pattern_en_i), .row_init(pat_first), .last_row(pat_last), .row(row_o)
  );

  assert_step_only_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |-> busy_o);
  assert_dst_still_paused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    paused_o && !start_i |=> $stable(dst_addr_o) && $stable(dst_off_o));
endmodule

// File: tb/tb_scanline_seq.sv
module tb_scanline_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int SW = 16;
  localparam int CW = 16;
  localparam longint PMASK = (64'd1 << (AW + 4)) - 1;

  logic clk = 0, rst_n = 0;
  logic start_i = 0, resume_i = 0, line_done_i = 0, irq_i = 0, pattern_en_i = 0;
  logic [AW-1:0] src_addr_i = 0, dst_addr_i = 0;
  logic [SW-1:0] src_bit_i = 0, src_stride_i = 0, dst_bit_i = 0, dst_stride_i = 0;
  logic [CW-1:0] height_i = 0, width_i = 0;
  logic [AW-1:0] src_addr_o, dst_addr_o;
  logic [5:0]    src_off_o, dst_off_o;
  logic [3:0]    row_o;
  logic          busy_o, paused_o, done_o;

  int n_run = 0, n_fail = 0;
  longint sp, dp;
  logic [3:0] erow;

  scanline_seq #(.AW(AW), .SW(SW), .CW(CW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint pos_of(input logic [AW-1:0] a, input logic [SW-1:0] b);
    return ((longint'(a) << 4) + longint'(b)) & PMASK;
  endfunction

  function automatic longint qaddr(input longint p);
    return ((p >> 6) << 2) & 64'hFFFF_FFFF;
  endfunction

  function automatic longint sstep(input longint p, input logic [SW-1:0] st);
    return (p + longint'($signed(st))) & PMASK;
  endfunction

  task automatic pulse_start();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
  endtask

  task automatic strobe(input logic irq);
    @(negedge clk) begin line_done_i = 1; irq_i = irq; end
    @(negedge clk) begin line_done_i = 0; irq_i = 0; end
  endtask

  task automatic check_lines(input string req);
    check({req, " src addr"}, src_addr_o, qaddr(sp));
    check({req, " src off"},  src_off_o, sp & 63);
    check({req, " dst addr"}, dst_addr_o, qaddr(dp));
    check({req, " dst off"},  dst_off_o, dp & 63);
  endtask

  // R2 R3 R4: plain walk with model in bit positions
  task automatic run_plain(input logic [AW-1:0] sa, input logic [SW-1:0] sb,
                           input logic [SW-1:0] ss, input logic [AW-1:0] da,
                           input logic [SW-1:0] db, input logic [SW-1:0] ds,
                           input int h);
    src_addr_i = sa; src_bit_i = sb; src_stride_i = ss;
    dst_addr_i = da; dst_bit_i = db; dst_stride_i = ds;
    height_i = CW'(h); width_i = 16'd9; pattern_en_i = 0;
    pulse_start();
    sp = pos_of(sa, sb); dp = pos_of(da, db);
    check("R2 busy", busy_o, 1);
    for (int i = 0; i < h; i++) begin
      check_lines(i == 0 ? "R2" : "R3");
      check("R7 row zero", row_o, 0);
      strobe(1'b0);
      if (i < h - 1) begin
        sp = sstep(sp, ss); dp = sstep(dp, ds);
        check("R4 not done", done_o, 0);
      end
    end
    check("R4 done", done_o, 1);
    check("R4 busy low", busy_o, 0);
    check_lines("R4 last hold");
  endtask

  initial begin
    int bits_t[5]    = '{0, 5, 17, 63, 200};
    int strides_t[8] = '{1, -1, 37, -100, 64, -64, 32767, -32768};
    #(CLK_PERIOD * 3);
    check("R1 busy", busy_o, 0);
    check("R1 paused", paused_o, 0);
    check("R1 done", done_o, 0);
    check("R1 src addr", src_addr_o, 0);
    check("R1 dst off", dst_off_o, 0);
    check("R1 row", row_o, 0);
    rst_n = 1;

    // R10: line_done and resume while idle
    strobe(1'b0);
    @(negedge clk) resume_i = 1;
    @(negedge clk) resume_i = 0;
    check("R10 idle busy", busy_o, 0);
    check("R10 idle paused", paused_o, 0);
    check("R10 idle addr", src_addr_o, 0);

    // R2 R3 R4 sweep
    for (int b = 0; b < 5; b++)
      for (int s = 0; s < 8; s++)
        for (int h = 1; h <= 3; h += 2)
          run_plain(32'h0000_1000 + 32'(b * 7), SW'(bits_t[b]), SW'(strides_t[s]),
                    32'hFFFF_FFFC - 32'(s), SW'(bits_t[(b + 1) % 5]),
                    SW'(strides_t[7 - s]), h);

    // R10: line_done after done has no effect
    strobe(1'b0);
    check("R10 after done", done_o, 1);
    check_lines("R10 after done");

    // R5: zero height, zero width
    height_i = 0; width_i = 5;
    pulse_start();
    check("R5 zero height done", done_o, 1);
    check("R5 zero height busy", busy_o, 0);
    height_i = 4; width_i = 0;
    pulse_start();
    check("R5 zero width done", done_o, 1);
    check("R5 zero width busy", busy_o, 0);

    // R6 R7: pattern sweep
    for (int lim = 0; lim < 4; lim++)
      for (int r0 = 0; r0 < 4; r0++) begin
        longint pbase;
        src_addr_i = 32'h0000_0002 + 32'(lim);
        src_stride_i = {4'(lim), 4'h0, 4'(r0), 4'h0};
        dst_addr_i = 32'h100; dst_bit_i = 16'd3; dst_stride_i = 16'd48;
        height_i = 6; width_i = 1; pattern_en_i = 1;
        pulse_start();
        pattern_en_i = 0;
        pbase = (longint'(src_addr_i) - r0) & 64'hFFFF_FFFF;
        erow = 4'(r0);
        dp = pos_of(dst_addr_i, dst_bit_i);
        for (int i = 0; i < 6; i++) begin
          check("R6 base", src_addr_o, pbase);
          check("R6 off", src_off_o, 0);
          check("R7 row", row_o, erow);
          check("R3 dst", dst_addr_o, qaddr(dp));
          strobe(1'b0);
          erow = (erow == 4'(lim)) ? 4'd0 : erow + 4'd1;
          dp = sstep(dp, dst_stride_i);
        end
        check("R4 pattern done", done_o, 1);
      end

    // R8 R9: park and resume
    run_plain(32'h200, 16'd10, 16'd100, 32'h300, 16'd60, -16'sd30, 1);
    src_addr_i = 32'h500; src_bit_i = 16'd21; src_stride_i = 16'd70;
    dst_addr_i = 32'h600; dst_bit_i = 16'd2;  dst_stride_i = -16'sd90;
    height_i = 3; width_i = 8; pattern_en_i = 0;
    pulse_start();
    sp = pos_of(32'h500, 16'd21); dp = pos_of(32'h600, 16'd2);
    strobe(1'b1);
    sp = sstep(sp, 16'd70); dp = sstep(dp, -16'sd90);
    check("R8 paused", paused_o, 1);
    check("R8 busy low", busy_o, 0);
    check_lines("R8 advanced");
    strobe(1'b0);
    check_lines("R8 strobe ignored");
    check("R8 still paused", paused_o, 1);
    src_addr_i = 32'hDEAD; dst_addr_i = 32'hBEEF; src_stride_i = 16'd1; height_i = 9;
    @(negedge clk) resume_i = 1;
    @(negedge clk) resume_i = 0;
    check("R9 busy", busy_o, 1);
    check_lines("R9 retained");
    strobe(1'b0);
    sp = sstep(sp, 16'd70); dp = sstep(dp, -16'sd90);
    check_lines("R9 continues");
    check("R9 not done", done_o, 0);
    strobe(1'b0);
    check("R9 count kept", done_o, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule